// File: doc/BRIEF.md
# Setup and Stimulation Safety Counter

This block sequences the start of a stimulation pulse in a wirelessly powered nerve stimulator and limits how long that pulse may last. One 5-bit register does both jobs. During setup it counts pulses that mark ultrasound carrier cycles. The first pulse only arms the counter. Each later pulse increments it, so after seventeen pulses the most significant bit is set and the lower four bits are zero. That most significant bit alone drives the stimulation-start output.

Once stimulation is active, the four lower bits become a safety timer. They are clocked by a free-running model of a delay chain: eight taps that fill one after another, one tap per tick of a prescaler. The chain's input is the inverse of its last tap, so when the last tap goes high the whole chain collapses in a single tick and then starts filling again. Each rising edge of the last tap counts one pass. The fourteenth pass drops an active-low stop output for one clock, which the surrounding logic uses to abort the stimulation. When stimulation ends, the chain and the four lower bits clear, so the next command starts with a full time budget.

Top module: `stim_guard_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `stim_start` and `tmr_clk` go low after that edge and `stop_n` goes high.
- R2: The first `us_pulse` after reset only arms the counter. Each later pulse adds one, so `stim_start` is high after exactly 17 pulses and still low after 16.
- R3: Once `stim_start` is high it stays high until reset, and further `us_pulse` inputs have no effect. A timeout after extra pulses takes exactly as long as one without them.
- R4: With TICK_CYC = T and 8 taps, if `stim_on` is first sampled high at clock edge 1, `tmr_clk` first goes high after edge 8T.
- R5: While `stim_on` stays high, `tmr_clk` repeats with a period of 9T cycles and stays high for T cycles of each period.
- R6: With `stim_start` high and `stim_on` held high from edge 1, `stop_n` goes low after edge 8T + 13·9T + 1, which is the fourteenth pass. It stays low for exactly one cycle.
- R7: One clock edge that samples `stim_on` low drives `tmr_clk` low, and it stays low while `stim_on` stays low.
- R8: When `stim_on` falls before the limit, the pass count clears. The next stimulation again takes the full R6 time to time out.
- R9: After the stop pulse, if `stim_on` remains high, no further stop pulse is produced.
- R10: While `stim_start` is low, `stop_n` stays high even when `stim_on` is high and the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_pulse | input | 1 | One-cycle pulse per ultrasound carrier cycle |
| stim_on | input | 1 | Level, high while stimulation is active |
| stim_start | output | 1 | Setup complete; the counter's MSB |
| tmr_clk | output | 1 | Last tap of the recycling delay chain |
| stop_n | output | 1 | Active-low, one-cycle timeout pulse |

## Verification
The properties assume that `us_pulse` and `stim_on` are synchronous to `clk` and that `stim_on` is a level, not a glitch. They also assume that stimulation only counts toward a timeout after setup has completed. The stimulus changes every input on the falling clock edge and holds `stim_on` for many cycles. It raises `stim_on` both before and after setup completes, which exercises the gating of the stop pulse without violating these assumptions.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int SG_CNT_W    = 5;
    localparam int SG_TAPS     = 8;
    localparam int SG_LIMIT    = 14;
    localparam int SG_TICK_CYC = 4;

    typedef enum logic [1:0] {
        CNT_IDLE  = 2'd0,
        CNT_SETUP = 2'd1,
        CNT_GUARD = 2'd2
    } cnt_mode_t;

    // Width of a counter that must hold values 0 .. n-1, at least one bit.
    function automatic int span_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sg_tick_gen.sv
module sg_tick_gen #(
    parameter int TICK_CYC = sg_pkg::SG_TICK_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = sg_pkg::span_w(TICK_CYC);
    localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

    logic [TW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/sg_tap_chain.sv
module sg_tap_chain #(
    parameter int TAPS = sg_pkg::SG_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic last_tap,
    output logic pass_rise
);
    logic [TAPS-1:0] tap_q;
    logic [TAPS-1:0] tap_d;
    logic            last_q;

    // Chain feed is the inverse of the final tap; a high final tap collapses every stage.
    for (genvar i = 0; i < TAPS; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign tap_d[i] = ~tap_q[TAPS-1];
        end else begin : g_body
            assign tap_d[i] = tap_q[TAPS-1] ? 1'b0 : tap_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tap_q <= '0;
        end else if (tick) begin
            tap_q <= tap_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
        end else begin
            last_q <= tap_q[TAPS-1];
        end
    end

    assign last_tap  = tap_q[TAPS-1];
    assign pass_rise = tap_q[TAPS-1] && !last_q;
endmodule

// File: rtl/sg_count_core.sv
module sg_count_core
    import sg_pkg::*;
#(
    parameter int CNT_W = SG_CNT_W,
    parameter int LIMIT = SG_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic us_pulse,
    input  logic stim_on,
    input  logic pass_rise,
    output logic stim_start,
    output logic stop_n
);
    localparam int LOW_W = CNT_W - 1;
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'((1 << LOW_W) - 1);
    localparam logic [LOW_W-1:0] LIM_V      = LOW_W'(LIMIT);
    localparam logic [LOW_W-1:0] LIM_PRE    = LOW_W'(LIMIT - 1);

    cnt_mode_t        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CNT_IDLE;
            cnt_q  <= '0;
            stop_q <= 1'b1;
        end else begin
            stop_q <= 1'b1;
            case (mode_q)
                CNT_IDLE: begin
                    if (us_pulse) begin
                        mode_q <= CNT_SETUP;
                    end
                end
                CNT_SETUP: begin
                    if (us_pulse) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == SETUP_LAST) begin
                            mode_q <= CNT_GUARD;
                        end
                    end
                end
                CNT_GUARD: begin
                    if (!stim_on) begin
                        cnt_q[LOW_W-1:0] <= '0;
                    end else if (pass_rise && (cnt_q[LOW_W-1:0] != LIM_V)) begin
                        cnt_q[LOW_W-1:0] <= cnt_q[LOW_W-1:0] + 1'b1;
                        if (cnt_q[LOW_W-1:0] == LIM_PRE) begin
                            stop_q <= 1'b0;
                        end
                    end
                end
                default: mode_q <= CNT_IDLE;
            endcase
        end
    end

    assign stim_start = cnt_q[CNT_W-1];
    assign stop_n     = stop_q;
endmodule

// File: rtl/stim_guard_counter.sv
module stim_guard_counter
    import sg_pkg::*;
#(
    parameter int CNT_W    = SG_CNT_W,
    parameter int TAPS     = SG_TAPS,
    parameter int LIMIT    = SG_LIMIT,
    parameter int TICK_CYC = SG_TICK_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic us_pulse,
    input  logic stim_on,
    output logic stim_start,
    output logic tmr_clk,
    output logic stop_n
);
    logic tick;
    logic last_tap;
    logic pass_rise;

    sg_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (stim_on),
        .tick (tick)
    );

    sg_tap_chain #(.TAPS(TAPS)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .run       (stim_on),
        .tick      (tick),
        .last_tap  (last_tap),
        .pass_rise (pass_rise)
    );

    sg_count_core #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_core (
        .clk        (clk),
        .rst        (rst),
        .us_pulse   (us_pulse),
        .stim_on    (stim_on),
        .pass_rise  (pass_rise),
        .stim_start (stim_start),
        .stop_n     (stop_n)
    );

    assign tmr_clk = last_tap;
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
    input logic clk,
    input logic rst,
    input logic us_pulse,
    input logic stim_on,
    input logic stim_start,
    input logic tmr_clk,
    input logic stop_n
);
    // R6
    stop_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_n |=> stop_n);

    // R3
    start_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stim_start |=> stim_start);

    // R7
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !stim_on |=> !tmr_clk);

    // R10
    stop_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> stim_start);

    // R6
    stop_in_stim_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> $past(stim_on));

    // R4
    tmr_rise_in_stim_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_clk) |-> $past(stim_on));
endmodule

bind stim_guard_counter sg_checker u_sg_checker (
    .clk        (clk),
    .rst        (rst),
    .us_pulse   (us_pulse),
    .stim_on    (stim_on),
    .stim_start (stim_start),
    .tmr_clk    (tmr_clk),
    .stop_n     (stop_n)
);

// File: tb/tb_stim_guard_counter.sv
`timescale 1ns/1ps
module tb_stim_guard_counter;
    localparam int T     = 4;
    localparam int TAPS  = 8;
    localparam int LIMIT = 14;
    localparam int FIRST_RISE = TAPS * T;
    localparam int PERIOD     = (TAPS + 1) * T;
    localparam int STOP_EDGE  = TAPS * T + (LIMIT - 1) * PERIOD + 1;
    localparam int NVEC = 6;
    localparam int VEC_PULSES [NVEC] = '{0, 1, 2, 16, 17, 25};
    localparam bit VEC_START  [NVEC] = '{0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_pulse = 1'b0;
    logic stim_on = 1'b0;
    logic stim_start, tmr_clk, stop_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    stim_guard_counter #(.TAPS(TAPS), .LIMIT(LIMIT), .TICK_CYC(T)) dut (
        .clk(clk), .rst(rst), .us_pulse(us_pulse), .stim_on(stim_on),
        .stim_start(stim_start), .tmr_clk(tmr_clk), .stop_n(stop_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; us_pulse = 1'b0; stim_on = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_pulse = 1'b1;
            @(negedge clk); us_pulse = 1'b0;
        end
    endtask

    // Raises stim_on and observes for ncyc edges; leaves stim_on high.
    task automatic run_stim(input int ncyc, output int rise1, output int rise2,
                            output int hi_w, output int stop_at, output int stop_w,
                            output int stop_cnt);
        int rises = 0;
        bit prev = 1'b0;
        bit sprev = 1'b1;
        rise1 = -1; rise2 = -1; hi_w = 0; stop_at = -1; stop_w = 0; stop_cnt = 0;
        @(negedge clk);
        stim_on = 1'b1;
        for (int m = 1; m <= ncyc; m++) begin
            @(posedge clk);
            @(negedge clk);
            if (tmr_clk && !prev) begin
                rises++;
                if (rises == 1) rise1 = m;
                if (rises == 2) rise2 = m;
            end
            if (tmr_clk && rises == 1) hi_w++;
            if (!stop_n) begin
                stop_w++;
                if (sprev) begin
                    stop_cnt++;
                    if (stop_at < 0) stop_at = m;
                end
            end
            prev = tmr_clk;
            sprev = stop_n;
        end
    endtask

    initial begin
        int r1, r2, hw, sa, sw, sc;
        bit bad;

        do_reset();
        @(negedge clk);
        check("R1 stim_start", stim_start, 0);
        check("R1 tmr_clk", tmr_clk, 0);
        check("R1 stop_n", stop_n, 1);

        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            send_pulses(VEC_PULSES[v]);
            @(negedge clk);
            check((VEC_PULSES[v] > 17) ? "R3 extra pulses" : "R2 setup count",
                  stim_start, VEC_START[v]);
        end

        // Full timeout after normal setup
        do_reset();
        send_pulses(17);
        run_stim(1300, r1, r2, hw, sa, sw, sc);
        check("R4 first tmr_clk rise", r1, FIRST_RISE);
        check("R5 tmr_clk period", r2 - r1, PERIOD);
        check("R5 tmr_clk high width", hw, T);
        check("R6 stop edge", sa, STOP_EDGE);
        check("R6 stop width", sw, 1);
        check("R9 single stop", sc, 1);
        check("R3 start held", stim_start, 1);

        // Stimulation ends: chain idles
        @(negedge clk);
        stim_on = 1'b0;
        @(negedge clk);
        check("R7 tmr_clk cleared", tmr_clk, 0);
        bad = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tmr_clk || !stop_n) bad = 1'b1;
        end
        check("R7 idle while stim off", bad, 0);

        // Early end, then a fresh command gets the full budget
        do_reset();
        send_pulses(17);
        run_stim(300, r1, r2, hw, sa, sw, sc);
        check("R8 no stop before limit", sc, 0);
        @(negedge clk);
        stim_on = 1'b0;
        repeat (5) @(negedge clk);
        run_stim(STOP_EDGE + 20, r1, r2, hw, sa, sw, sc);
        check("R8 full budget after early end", sa, STOP_EDGE);
        @(negedge clk);
        stim_on = 1'b0;

        // Extra setup pulses do not shorten the timeout
        do_reset();
        send_pulses(23);
        run_stim(STOP_EDGE + 20, r1, r2, hw, sa, sw, sc);
        check("R3 extra pulses ignored", sa, STOP_EDGE);
        @(negedge clk);
        stim_on = 1'b0;

        // Stimulation without completed setup
        do_reset();
        send_pulses(16);
        run_stim(STOP_EDGE + 100, r1, r2, hw, sa, sw, sc);
        check("R10 no stop before setup done", sc, 0);
        check("R4 timer runs before setup done", r1, FIRST_RISE);
        @(negedge clk);
        stim_on = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule